// File: doc/BRIEF.md
# CCD Frame and Line Timing Generator

This block is a counter-driven sequencer that produces the logic-level enables an interline CCD camera feeds to its external clock drivers. It generates the two vertical phases (with the second phase split into an even-row and an odd-row copy plus a third-level enable for each), the two horizontal phases, the per-pixel reset pulse and the substrate shutter pulse. It also gives capture logic a frame marker, a line-valid qualifier and the current field parity. Every duration is a number of master-clock cycles set by a parameter.

Each frame opens with a one-cycle start slot in which the readout configuration is sampled. A pedestal interval, a photodiode-transfer interval and a settle interval follow. Then come the readout lines. Each line shifts the vertical register one or two times, waits an HCCD delay (during which the shutter pulse may fire) and then clocks the horizontal register for a mode-dependent number of pixels. Reading more lines than the image holds stretches the exposure without the shutter. The extra lines are flagged invalid. Three readout styles are supported: progressive, interlaced with field integration (rows binned in pairs, both halves transferred), and interlaced with frame integration (only one field's photodiodes transferred per readout).

Top module: `ccd_timing_gen`

## Requirements
- R1: While rst_n is low, the outputs sit at the frame-start slot values: frame_start=1, field_odd=0, v1=0, v2e=v2o=1, v2e_hi=v2o_hi=0, h1=0, h2=1, rst_pix=0, sub_pulse=0, line_valid=0.
- R2: A frame is the frame_start cycle, then T_PED idle cycles, then T_PDX cycles of photodiode transfer, then T_PDD idle cycles, then the first line. rd_mode, dual_out, shutter_line and total_lines are sampled at the end of the frame_start cycle and hold for the whole frame.
- R3: rd_mode encoding: 0 and 3 progressive, 1 field integration, 2 frame integration. During photodiode transfer both v2e_hi and v2o_hi are high in progressive and field integration. In frame integration only v2e_hi is high on an even field and only v2o_hi on an odd field.
- R4: field_odd is 0 for progressive frames. Interlaced frames alternate even, odd, even, starting from even after reset or after any progressive frame. field_odd takes its new value in the cycle after frame_start.
- R5: Each line starts with one vertical shift slot (progressive) or two (interlaced), each T_VSLOT cycles long. v1 is high for the first V1_HIGH cycles of a slot.
- R6: Within a slot, v2e and v2o are low exactly for slot cycles T_VE up to V1_HIGH-T_VE-1. So V2 falls no earlier than V1 rises and rises no later than V1 falls.
- R7: After the shift slots come T_HD delay cycles, then horizontal clocking for PIX_SINGLE pixels when dual_out=0 or PIX_DUAL pixels when dual_out=1, each pixel 2*PIX_HALF cycles.
- R8: Within a pixel, h1 is high for the first PIX_HALF cycles and h2 is its complement. rst_pix is high for the first RST_W cycles. Outside horizontal clocking, h1=0, h2=1 and rst_pix=0.
- R9: The number of lines read per frame is the larger of total_lines and the image line count, which is ROWS for progressive and ROWS/2 for interlaced.
- R10: line_valid is high during horizontal clocking of line indices (from 0) below the image line count, and low at all other times.
- R11: When shutter_line=n is nonzero, sub_pulse is high on line n (counting from 1) for delay-interval cycles T_SD up to T_SD+T_S-1. A value of 0, or a value above the line count, produces no pulse.
- R12: frame_start lasts one cycle. The next frame_start follows immediately after the last pixel of the last line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_mode | input | 2 | Readout style (0/3 progressive, 1 field integration, 2 frame integration) |
| dual_out | input | 1 | 1 selects the dual-output pixel count |
| shutter_line | input | LINE_W | Line carrying the substrate pulse, 0 disables it |
| total_lines | input | LINE_W | Requested lines per readout |
| v1 | output | 1 | Vertical phase 1 enable |
| v2e | output | 1 | Vertical phase 2, even rows |
| v2o | output | 1 | Vertical phase 2, odd rows |
| v2e_hi | output | 1 | Third-level (photodiode transfer) enable, even rows |
| v2o_hi | output | 1 | Third-level (photodiode transfer) enable, odd rows |
| h1 | output | 1 | Horizontal phase 1 |
| h2 | output | 1 | Horizontal phase 2 |
| rst_pix | output | 1 | Output-node reset pulse |
| sub_pulse | output | 1 | Substrate shutter pulse |
| frame_start | output | 1 | First cycle of a frame |
| line_valid | output | 1 | Image pixels being shifted out |
| field_odd | output | 1 | Current field parity |

## Verification
The bench targets the seams between readout styles. A progressive frame placed between interlaced ones must restart the parity at even, and mode value 3 must act as progressive. A design that kept toggling parity, or that fed the wrong V2 half during frame integration, would show a third-level enable on the wrong output. The bench also requests more lines than the image holds, so the sequencer must keep clocking the extra lines with line_valid low and the frame length must grow. It places the shutter on the first line, on the last line and past the end, where an off-by-one line match would pulse on a neighbouring line or fire when it should not. Every cycle is compared against an independently built waveform, so a V2 edge outside the V1 window, a short pixel count in dual mode or a shift slot missing from an interlaced line shows up at its exact cycle.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

   // readout style as presented on rd_mode
   typedef enum logic [1:0] {
      RD_PROG     = 2'd0,
      RD_FIELD    = 2'd1,
      RD_FRAME    = 2'd2,
      RD_PROG_ALT = 2'd3
   } rd_mode_e;

   // sequencer phases, in order of occurrence within a frame
   typedef enum logic [2:0] {
      PH_LOAD = 3'd0,   // frame start slot, configuration sampled
      PH_PED  = 3'd1,   // pedestal before photodiode transfer
      PH_PDX  = 3'd2,   // photodiode transfer (third level)
      PH_PDD  = 3'd3,   // settle after transfer
      PH_VX   = 3'd4,   // vertical shift slot(s)
      PH_HD   = 3'd5,   // HCCD delay, shutter window
      PH_HC   = 3'd6    // horizontal clocking
   } phase_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ccd_tg_seq.sv
module ccd_tg_seq
   import ccd_tg_pkg::*;
#(
   parameter int ROWS       = 1092,
   parameter int PIX_SINGLE = 1988,
   parameter int PIX_DUAL   = 996,
   parameter int PIX_HALF   = 1,
   parameter int T_PED      = 2000,
   parameter int T_PDX      = 960,
   parameter int T_PDD      = 1600,
   parameter int T_VSLOT    = 240,
   parameter int T_HD       = 560,
   parameter int LINE_W     = 12,
   parameter int CNT_W      = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        rd_mode,
   input  logic              dual_out,
   input  logic [LINE_W-1:0] shutter_line,
   input  logic [LINE_W-1:0] total_lines,
   output phase_e            phase,
   output logic [CNT_W-1:0]  cnt,
   output logic [LINE_W-1:0] line_idx,
   output rd_mode_e          mode_cur,
   output logic [LINE_W-1:0] shut_cur,
   output logic [LINE_W-1:0] img_lines,
   output logic              field_odd
);

   localparam int HC_SINGLE = PIX_SINGLE * 2 * PIX_HALF;
   localparam int HC_DUAL   = PIX_DUAL * 2 * PIX_HALF;

   phase_e            phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_c;
   logic [LINE_W-1:0] line_q;
   logic              slot_q;
   rd_mode_e          mode_q;
   logic              dual_q;
   logic [LINE_W-1:0] shut_q;
   logic [LINE_W-1:0] nlines_q;
   logic              odd_q;
   logic              next_odd_q;

   logic              cur_prog;
   logic              in_prog;
   logic [LINE_W-1:0] in_img;
   logic [LINE_W-1:0] in_nlines;
   logic              ph_end;

   assign cur_prog  = (mode_q == RD_PROG) || (mode_q == RD_PROG_ALT);
   assign in_prog   = (rd_mode == 2'd0) || (rd_mode == 2'd3);
   assign in_img    = in_prog ? LINE_W'(ROWS) : LINE_W'(ROWS / 2);
   assign in_nlines = (total_lines > in_img) ? total_lines : in_img;
   assign img_lines = cur_prog ? LINE_W'(ROWS) : LINE_W'(ROWS / 2);

   // terminal count of the phase now running
   always_comb begin
      case (phase_q)
         PH_LOAD: last_c = '0;
         PH_PED:  last_c = CNT_W'(T_PED - 1);
         PH_PDX:  last_c = CNT_W'(T_PDX - 1);
         PH_PDD:  last_c = CNT_W'(T_PDD - 1);
         PH_VX:   last_c = CNT_W'(T_VSLOT - 1);
         PH_HD:   last_c = CNT_W'(T_HD - 1);
         PH_HC:   last_c = dual_q ? CNT_W'(HC_DUAL - 1) : CNT_W'(HC_SINGLE - 1);
         default: last_c = '0;
      endcase
   end

   assign ph_end = (cnt_q == last_c);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_LOAD;
         cnt_q      <= '0;
         line_q     <= '0;
         slot_q     <= 1'b0;
         mode_q     <= RD_PROG;
         dual_q     <= 1'b0;
         shut_q     <= '0;
         nlines_q   <= LINE_W'(ROWS);
         odd_q      <= 1'b0;
         next_odd_q <= 1'b0;
      end else begin
         cnt_q <= ph_end ? '0 : cnt_q + CNT_W'(1);
         if (ph_end) begin
            case (phase_q)
               PH_LOAD: begin
                  phase_q    <= PH_PED;
                  mode_q     <= rd_mode_e'(rd_mode);
                  dual_q     <= dual_out;
                  shut_q     <= shutter_line;
                  nlines_q   <= in_nlines;
                  odd_q      <= in_prog ? 1'b0 : next_odd_q;
                  next_odd_q <= in_prog ? 1'b0 : ~next_odd_q;
               end
               PH_PED: phase_q <= PH_PDX;
               PH_PDX: phase_q <= PH_PDD;
               PH_PDD: begin
                  phase_q <= PH_VX;
                  line_q  <= '0;
                  slot_q  <= 1'b0;
               end
               PH_VX: begin
                  // interlaced lines shift the vertical register twice
                  if (slot_q == ~cur_prog) begin
                     phase_q <= PH_HD;
                     slot_q  <= 1'b0;
                  end else begin
                     slot_q  <= 1'b1;
                  end
               end
               PH_HD: phase_q <= PH_HC;
               PH_HC: begin
                  if (line_q == nlines_q - LINE_W'(1)) begin
                     phase_q <= PH_LOAD;
                  end else begin
                     line_q  <= line_q + LINE_W'(1);
                     phase_q <= PH_VX;
                  end
               end
               default: phase_q <= PH_LOAD;
            endcase
         end
      end
   end

   assign phase     = phase_q;
   assign cnt       = cnt_q;
   assign line_idx  = line_q;
   assign mode_cur  = mode_q;
   assign shut_cur  = shut_q;
   assign field_odd = odd_q;

endmodule

// File: rtl/ccd_tg_vdrv.sv
module ccd_tg_vdrv
   import ccd_tg_pkg::*;
#(
   parameter int T_VE    = 4,
   parameter int V1_HIGH = 120,
   parameter int CNT_W   = 13
) (
   input  phase_e           phase,
   input  logic [CNT_W-1:0] cnt,
   input  rd_mode_e         mode_cur,
   input  logic             field_odd,
   output logic             v1,
   output logic             v2e,
   output logic             v2o,
   output logic             v2e_hi,
   output logic             v2o_hi
);

   logic in_vx;
   logic v1_win;
   logic v2_low;
   logic pd_xfer;
   logic split;

   assign in_vx  = (phase == PH_VX);
   assign v1_win = in_vx && (cnt < CNT_W'(V1_HIGH));

   // V2 low window sits inside the V1 high window, shrunk by T_VE each side
   generate
      if (T_VE == 0) begin : g_v2_flush
         assign v2_low = v1_win;
      end else begin : g_v2_skew
         assign v2_low = in_vx && (cnt >= CNT_W'(T_VE))
                               && (cnt < CNT_W'(V1_HIGH - T_VE));
      end
   endgenerate

   assign v1  = v1_win;
   assign v2e = ~v2_low;
   assign v2o = ~v2_low;

   // photodiode transfer: frame integration moves only one field's rows
   assign pd_xfer = (phase == PH_PDX);
   assign split   = (mode_cur == RD_FRAME);
   assign v2e_hi  = pd_xfer && !(split && field_odd);
   assign v2o_hi  = pd_xfer && !(split && !field_odd);

endmodule

// File: rtl/ccd_tg_hdrv.sv
module ccd_tg_hdrv
   import ccd_tg_pkg::*;
#(
   parameter int PIX_HALF = 1,
   parameter int RST_W    = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e phase,
   output logic   h1,
   output logic   h2,
   output logic   rst_pix
);

   localparam int PER = 2 * PIX_HALF;
   localparam int SW  = (PER <= 2) ? 1 : $clog2(PER);

   logic          act;
   logic [SW-1:0] sc_q;
   logic          first_half;

   assign act = (phase == PH_HC);

   // position inside the current pixel period; cleared outside clocking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_q <= '0;
      end else if (!act || (sc_q == SW'(PER - 1))) begin
         sc_q <= '0;
      end else begin
         sc_q <= sc_q + SW'(1);
      end
   end

   assign first_half = act && (sc_q < SW'(PIX_HALF));
   assign h1 = first_half;
   assign h2 = ~first_half;

   generate
      if (RST_W == PIX_HALF) begin : g_rst_half
         assign rst_pix = first_half;
      end else begin : g_rst_short
         assign rst_pix = act && (sc_q < SW'(RST_W));
      end
   endgenerate

endmodule

// File: rtl/ccd_tg_aux.sv
module ccd_tg_aux
   import ccd_tg_pkg::*;
#(
   parameter int T_SD   = 128,
   parameter int T_S    = 400,
   parameter int CNT_W  = 13,
   parameter int LINE_W = 12
) (
   input  phase_e            phase,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [LINE_W-1:0] line_idx,
   input  logic [LINE_W-1:0] shut_cur,
   input  logic [LINE_W-1:0] img_lines,
   output logic              sub_pulse,
   output logic              line_valid,
   output logic              frame_start
);

   logic line_hit;
   logic win;

   assign line_hit = (shut_cur != '0) && ((line_idx + LINE_W'(1)) == shut_cur);
   assign win      = (cnt >= CNT_W'(T_SD)) && (cnt < CNT_W'(T_SD + T_S));

   assign sub_pulse   = (phase == PH_HD) && line_hit && win;
   assign line_valid  = (phase == PH_HC) && (line_idx < img_lines);
   assign frame_start = (phase == PH_LOAD);

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
   import ccd_tg_pkg::*;
#(
   parameter int ROWS       = 1092,
   parameter int PIX_SINGLE = 1988,
   parameter int PIX_DUAL   = 996,
   parameter int PIX_HALF   = 1,
   parameter int RST_W      = 1,
   parameter int T_PED      = 2000,
   parameter int T_PDX      = 960,
   parameter int T_PDD      = 1600,
   parameter int T_VSLOT    = 240,
   parameter int V1_HIGH    = 120,
   parameter int T_VE       = 4,
   parameter int T_HD       = 560,
   parameter int T_SD       = 128,
   parameter int T_S        = 400,
   parameter int LINE_W     = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        rd_mode,
   input  logic              dual_out,
   input  logic [LINE_W-1:0] shutter_line,
   input  logic [LINE_W-1:0] total_lines,
   output logic              v1,
   output logic              v2e,
   output logic              v2o,
   output logic              v2e_hi,
   output logic              v2o_hi,
   output logic              h1,
   output logic              h2,
   output logic              rst_pix,
   output logic              sub_pulse,
   output logic              frame_start,
   output logic              line_valid,
   output logic              field_odd
);

   localparam int unsigned LEN_HEAD = max_u(max_u(T_PED, T_PDX), T_PDD);
   localparam int unsigned LEN_LINE = max_u(T_VSLOT, T_HD);
   localparam int unsigned LEN_PIX  = max_u(PIX_SINGLE, PIX_DUAL) * 2 * PIX_HALF;
   localparam int unsigned MAX_LEN  = max_u(max_u(LEN_HEAD, LEN_LINE), LEN_PIX);
   localparam int          CNT_W    = $clog2(MAX_LEN + 1);

   // parameter sanity, evaluated at elaboration
   generate
      if (T_PED < 1 || T_PDX < 1 || T_PDD < 1 || T_HD < 1) begin : g_bad_len
         $error("ccd_timing_gen: every interval must last at least one cycle");
      end
      if (V1_HIGH >= T_VSLOT || 2 * T_VE >= V1_HIGH) begin : g_bad_vert
         $error("ccd_timing_gen: vertical slot shape is inconsistent");
      end
      if (T_SD < 1 || T_S < 1 || T_SD + T_S > T_HD) begin : g_bad_shut
         $error("ccd_timing_gen: shutter window must fit inside the HCCD delay");
      end
      if (PIX_HALF < 1 || RST_W < 1 || RST_W > PIX_HALF) begin : g_bad_pix
         $error("ccd_timing_gen: pixel period parameters are inconsistent");
      end
      if (ROWS < 2 || (ROWS % 2) != 0 || ROWS >= (1 << LINE_W)) begin : g_bad_rows
         $error("ccd_timing_gen: ROWS must be even and fit in LINE_W bits");
      end
      if (PIX_DUAL < 1 || PIX_DUAL > PIX_SINGLE) begin : g_bad_dual
         $error("ccd_timing_gen: dual pixel count must not exceed single");
      end
   endgenerate

   phase_e            phase;
   logic [CNT_W-1:0]  cnt;
   logic [LINE_W-1:0] line_idx;
   rd_mode_e          mode_cur;
   logic [LINE_W-1:0] shut_cur;
   logic [LINE_W-1:0] img_lines;

   ccd_tg_seq #(
      .ROWS       (ROWS),
      .PIX_SINGLE (PIX_SINGLE),
      .PIX_DUAL   (PIX_DUAL),
      .PIX_HALF   (PIX_HALF),
      .T_PED      (T_PED),
      .T_PDX      (T_PDX),
      .T_PDD      (T_PDD),
      .T_VSLOT    (T_VSLOT),
      .T_HD       (T_HD),
      .LINE_W     (LINE_W),
      .CNT_W      (CNT_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_mode      (rd_mode),
      .dual_out     (dual_out),
      .shutter_line (shutter_line),
      .total_lines  (total_lines),
      .phase        (phase),
      .cnt          (cnt),
      .line_idx     (line_idx),
      .mode_cur     (mode_cur),
      .shut_cur     (shut_cur),
      .img_lines    (img_lines),
      .field_odd    (field_odd)
   );

   ccd_tg_vdrv #(
      .T_VE    (T_VE),
      .V1_HIGH (V1_HIGH),
      .CNT_W   (CNT_W)
   ) u_vdrv (
      .phase     (phase),
      .cnt       (cnt),
      .mode_cur  (mode_cur),
      .field_odd (field_odd),
      .v1        (v1),
      .v2e       (v2e),
      .v2o       (v2o),
      .v2e_hi    (v2e_hi),
      .v2o_hi    (v2o_hi)
   );

   ccd_tg_hdrv #(
      .PIX_HALF (PIX_HALF),
      .RST_W    (RST_W)
   ) u_hdrv (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase   (phase),
      .h1      (h1),
      .h2      (h2),
      .rst_pix (rst_pix)
   );

   ccd_tg_aux #(
      .T_SD   (T_SD),
      .T_S    (T_S),
      .CNT_W  (CNT_W),
      .LINE_W (LINE_W)
   ) u_aux (
      .phase       (phase),
      .cnt         (cnt),
      .line_idx    (line_idx),
      .shut_cur    (shut_cur),
      .img_lines   (img_lines),
      .sub_pulse   (sub_pulse),
      .line_valid  (line_valid),
      .frame_start (frame_start)
   );

endmodule

// File: rtl/ccd_timing_gen_chk.sv
module ccd_timing_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic v1,
   input logic v2e,
   input logic v2o,
   input logic v2e_hi,
   input logic v2o_hi,
   input logic h1,
   input logic h2,
   input logic rst_pix,
   input logic sub_pulse,
   input logic frame_start,
   input logic line_valid
);

   assert_v2_fall_inside_v1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(v2e) |-> v1);

   assert_v2_rise_before_v1_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(v2o) |-> $past(v1));

   assert_even_odd_shift_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (v2e_hi == 1'b0 && v2o_hi == 1'b0) |-> (v2e == v2o));

   assert_xfer_only_at_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (v2e_hi || v2o_hi) |-> (v2e && v2o && !v1 && !h1));

   assert_h_phases_opposed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      h1 != h2);

   assert_reset_in_h1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pix |-> h1);

   assert_shutter_in_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sub_pulse |-> (!h1 && !v1 && !line_valid));

   assert_valid_not_in_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid |-> (!v1 && v2e));

   assert_frame_start_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

endmodule

bind ccd_timing_gen ccd_timing_gen_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .v1          (v1),
   .v2e         (v2e),
   .v2o         (v2o),
   .v2e_hi      (v2e_hi),
   .v2o_hi      (v2o_hi),
   .h1          (h1),
   .h2          (h2),
   .rst_pix     (rst_pix),
   .sub_pulse   (sub_pulse),
   .frame_start (frame_start),
   .line_valid  (line_valid)
);

// File: tb/ccd_timing_gen_test.sv
module ccd_timing_gen_test;

   localparam int ROWS    = 6;
   localparam int PIX_S   = 10;
   localparam int PIX_D   = 5;
   localparam int PH      = 2;
   localparam int RW      = 1;
   localparam int T_PED   = 3;
   localparam int T_PDX   = 4;
   localparam int T_PDD   = 2;
   localparam int T_VSLOT = 8;
   localparam int V1H     = 5;
   localparam int T_VE    = 1;
   localparam int T_HD    = 7;
   localparam int T_SD    = 2;
   localparam int T_S     = 3;
   localparam int LW      = 5;
   localparam int NF      = 8;

   // bit positions of the observed output vector
   localparam int B_FS = 11, B_OD = 10, B_V1 = 9, B_VE = 8, B_VO = 7, B_HE = 6;
   localparam int B_HO = 5,  B_H1 = 4,  B_H2 = 3, B_RP = 2, B_SB = 1, B_LV = 0;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [1:0]    rd_mode;
   logic          dual_out;
   logic [LW-1:0] shutter_line;
   logic [LW-1:0] total_lines;
   logic v1, v2e, v2o, v2e_hi, v2o_hi, h1, h2, rst_pix, sub_pulse;
   logic frame_start, line_valid, field_odd;

   always #4 clk = ~clk;

   ccd_timing_gen #(
      .ROWS(ROWS), .PIX_SINGLE(PIX_S), .PIX_DUAL(PIX_D), .PIX_HALF(PH), .RST_W(RW),
      .T_PED(T_PED), .T_PDX(T_PDX), .T_PDD(T_PDD), .T_VSLOT(T_VSLOT),
      .V1_HIGH(V1H), .T_VE(T_VE), .T_HD(T_HD), .T_SD(T_SD), .T_S(T_S), .LINE_W(LW)
   ) uut (
      .clk(clk), .rst_n(rst_n), .rd_mode(rd_mode), .dual_out(dual_out),
      .shutter_line(shutter_line), .total_lines(total_lines),
      .v1(v1), .v2e(v2e), .v2o(v2o), .v2e_hi(v2e_hi), .v2o_hi(v2o_hi),
      .h1(h1), .h2(h2), .rst_pix(rst_pix), .sub_pulse(sub_pulse),
      .frame_start(frame_start), .line_valid(line_valid), .field_odd(field_odd)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [11:0] expq[$];
   int mdl_odd  = 0;
   int mdl_next = 0;

   // per-frame stimulus: mode, dual, shutter line, requested lines
   int cf_mode [NF] = '{0, 1, 1, 2, 2, 0, 3, 2};
   int cf_dual [NF] = '{0, 1, 1, 0, 1, 1, 0, 0};
   int cf_shut [NF] = '{0, 2, 0, 3, 9, 1, 6, 0};
   int cf_tot  [NF] = '{0, 0, 0, 5, 0, 9, 0, 0};

   string fname [12] = '{"line_valid", "sub_pulse", "rst_pix", "h2", "h1", "v2o_hi",
                         "v2e_hi", "v2o", "v2e", "v1", "field_odd", "frame_start"};
   string freq  [12] = '{"R10", "R11", "R8", "R8", "R8", "R3",
                         "R3", "R6", "R6", "R5", "R4", "R12"};

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [11:0] idle_vec(input int odd);
      logic [11:0] v = '0;
      v[B_OD] = (odd != 0);
      v[B_VE] = 1'b1;
      v[B_VO] = 1'b1;
      v[B_H2] = 1'b1;
      return v;
   endfunction

   function automatic logic [11:0] observe();
      return {frame_start, field_odd, v1, v2e, v2o, v2e_hi, v2o_hi,
              h1, h2, rst_pix, sub_pulse, line_valid};
   endfunction

   // expected waveform of one whole frame, cycle by cycle
   task automatic build(input int m, input int d, input int s, input int t,
                        output int flen, output int npx, output int head);
      bit prog = !(m == 1 || m == 2);
      int img, n, nsh, np;
      logic [11:0] b, v;
      b = idle_vec(mdl_odd);
      b[B_FS] = 1'b1;
      expq.push_back(b);
      mdl_odd  = prog ? 0 : mdl_next;
      mdl_next = prog ? 0 : 1 - mdl_next;
      img = prog ? ROWS : ROWS / 2;
      n   = (t > img) ? t : img;
      nsh = prog ? 1 : 2;
      np  = d ? PIX_D : PIX_S;
      b = idle_vec(mdl_odd);
      repeat (T_PED) expq.push_back(b);
      v = b;
      v[B_HE] = !(m == 2 && mdl_odd == 1);
      v[B_HO] = !(m == 2 && mdl_odd == 0);
      repeat (T_PDX) expq.push_back(v);
      repeat (T_PDD) expq.push_back(b);
      for (int l = 0; l < n; l++) begin
         for (int sh = 0; sh < nsh; sh++) begin
            for (int c = 0; c < T_VSLOT; c++) begin
               v = b;
               v[B_V1] = (c < V1H);
               v[B_VE] = !(c >= T_VE && c < V1H - T_VE);
               v[B_VO] = v[B_VE];
               expq.push_back(v);
            end
         end
         for (int c = 0; c < T_HD; c++) begin
            v = b;
            v[B_SB] = (s != 0) && (s == l + 1) && (c >= T_SD) && (c < T_SD + T_S);
            expq.push_back(v);
         end
         for (int p = 0; p < np; p++) begin
            for (int c = 0; c < 2 * PH; c++) begin
               v = b;
               v[B_H1] = (c < PH);
               v[B_H2] = !(c < PH);
               v[B_RP] = (c < RW);
               v[B_LV] = (l < img);
               expq.push_back(v);
            end
         end
      end
      flen = 1 + T_PED + T_PDX + T_PDD + n * (nsh * T_VSLOT + T_HD + np * 2 * PH);
      npx  = n * np;
      head = 1 + T_PED + T_PDX + T_PDD;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R12 watchdog: actual no frame completion expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int frm = 0;
      int exp_len = 0, exp_px = 0, exp_head = 0;
      int cyc = 0, h1_rises = 0, first_v1 = -1;
      logic prev_h1 = 1'b0;
      logic [11:0] act, exp;

      rst_n = 1'b0;
      rd_mode = 2'd0;
      dual_out = 1'b0;
      shutter_line = '0;
      total_lines = '0;
      repeat (3) @(negedge clk);
      // R1: outputs while held in reset
      chk("R1", "reset output vector", int'(observe()), int'(idle_vec(0) | 12'h800));

      forever begin
         if (expq.size() == 0) begin
            if (frm > 0) begin
               chk("R9", "frame length in cycles", cyc, exp_len);
               chk("R7", "h1 pulses per frame", h1_rises, exp_px);
               chk("R2", "cycles before first V1 rise", first_v1, exp_head);
            end
            if (frm == NF) break;
            rd_mode      = 2'(cf_mode[frm]);
            dual_out     = (cf_dual[frm] != 0);
            shutter_line = LW'(cf_shut[frm]);
            total_lines  = LW'(cf_tot[frm]);
            rst_n        = 1'b1;
            build(cf_mode[frm], cf_dual[frm], cf_shut[frm], cf_tot[frm],
                  exp_len, exp_px, exp_head);
            frm++;
            cyc = 0;
            h1_rises = 0;
            first_v1 = -1;
            prev_h1 = 1'b0;
         end
         exp = expq.pop_front();
         act = observe();
         for (int k = 0; k < 12; k++) begin
            chk(freq[k], fname[k], int'(act[k]), int'(exp[k]));
         end
         if (act[B_H1] && !prev_h1) h1_rises++;
         if (act[B_V1] && first_v1 < 0) first_v1 = cyc;
         prev_h1 = act[B_H1];
         cyc++;
         @(negedge clk);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule